// File: doc/BRIEF.md
# DMA Request Falling-Edge Acceptance Controller

This block sits between an active-low external DMA request pin and a single-channel transfer engine that runs in normal mode. Once software finishes the control write that enables transfer, the controller samples the synchronized pin on every clock. A low level seen while acceptance is open is latched as a held request. At the next bus break the held request is cleared and a bus release of a fixed number of cycles follows. The engine then runs one read cycle from the source and one write cycle to the destination.

A falling edge is recognised by alternating between two sampling phases, not by a free-running edge detector. While a transfer is running, low-level acceptance is closed and the pin is watched for a high level. Acceptance reopens after the write cycle ends, and only once a high has been seen. A pin that is held low therefore yields exactly one transfer. A transfer counter, loaded by the enable strobe, stops acceptance when it reaches zero and raises transfer-complete. A disable strobe returns the controller to idle at any point.

Top module: `dreq_edge_ctrl`

## Requirements
- R1: After reset, and until an enable strobe, all outputs are low and a low level on the request pin is not latched.
- R2: The request pin passes through a two-flop synchronizer and is sampled from the clock edge that follows the enable strobe onward. While acceptance is open, a low driven before clock edge N sets `req_held` after edge N+2.
- R3: `req_held` stays high until a clock edge at which `bus_break` is high, and falls at that edge.
- R4: After the edge that clears `req_held`, `rd_cyc` stays low for RELEASE_CYC cycles (default 2) and then rises.
- R5: `rd_cyc` stays high until an edge with `rd_done` high. `wr_cyc` then holds high from that edge until an edge with `wr_done` high. At most one of `rd_cyc`, `wr_cyc`, `req_held` and `xfer_done` is high at any time.
- R6: A low level during the read or write cycle is never accepted. If the pin has stayed low through the end of the write, no new request is latched until the pin has gone high and then low again.
- R7: If a high level was sampled during the read or write cycle, acceptance reopens right after the write ends, so that a new low is latched with the R2 latency.
- R8: The enable strobe loads `count_in`, and each completed write decrements the count. When the last write ends, `xfer_done` rises and later lows on the pin are ignored. A count of zero raises `xfer_done` one edge after the strobe.
- R9: A disable strobe clears any held request or running cycle, drops every output to low on the next edge and closes acceptance. It takes priority over an enable strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle strobe at the end of the enabling control write; loads the count |
| disarm | input | 1 | One-cycle strobe that disables transfer and returns to idle |
| count_in | input | CNT_W | Number of transfers to perform |
| req_n | input | 1 | Active-low external DMA request pin (asynchronous) |
| bus_break | input | 1 | High in a cycle where the bus can be released to DMA |
| rd_done | input | 1 | Source read cycle completes this cycle |
| wr_done | input | 1 | Destination write cycle completes this cycle |
| rd_cyc | output | 1 | Source read cycle in progress |
| wr_cyc | output | 1 | Destination write cycle in progress |
| req_held | output | 1 | A request has been accepted and is held |
| xfer_done | output | 1 | Transfer count has been exhausted |

## Verification
The assertions check the cycle-level ordering on every clock. They cover the exclusivity of the four outputs and how a held request persists and then clears on a bus break. They also check the release gap before the read, the read-to-write handover, that a new hold never follows a bus cycle directly, and the return to idle on disable. Only the bench scenarios can show the things that depend on pin history and count: the three-edge acceptance latency, the refusal of a pin left low across a write, reopening after a high seen mid-transfer, and completion after exactly the loaded number of writes.

// File: rtl/dreq_edge_ctrl.sv
module dreq_edge_ctrl #(
  parameter int CNT_W       = 8,
  parameter int RELEASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             disarm,
  input  logic [CNT_W-1:0] count_in,
  input  logic             req_n,
  input  logic             bus_break,
  input  logic             rd_done,
  input  logic             wr_done,
  output logic             rd_cyc,
  output logic             wr_cyc,
  output logic             req_held,
  output logic             xfer_done
);

  localparam int REL_W = (RELEASE_CYC > 1) ? $clog2(RELEASE_CYC) : 1;
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_HOLD, ST_RELEASE, ST_READ, ST_WRITE, ST_REARM, ST_FINISH
  } state_t;

  state_t           state;
  logic [1:0]       pin_s;
  logic [CNT_W-1:0] remain;
  logic [REL_W-1:0] rel_cnt;
  logic             hi_seen;
  logic             pin_hi;

  assign pin_hi    = pin_s[1];
  assign rd_cyc    = (state == ST_READ);
  assign wr_cyc    = (state == ST_WRITE);
  assign req_held  = (state == ST_HOLD);
  assign xfer_done = (state == ST_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pin_s   <= 2'b11;
      remain  <= '0;
      rel_cnt <= '0;
      hi_seen <= 1'b0;
    end else begin
      pin_s <= {pin_s[0], req_n};
      if (disarm) begin
        state <= ST_IDLE;
      end else if (arm) begin
        remain <= count_in;
        state  <= (count_in == '0) ? ST_FINISH : ST_OPEN;
      end else begin
        unique case (state)
          ST_OPEN:    if (!pin_hi) state <= ST_HOLD;
          ST_HOLD:    if (bus_break) begin
                        state   <= ST_RELEASE;
                        rel_cnt <= '0;
                      end
          ST_RELEASE: if (rel_cnt == REL_LAST) begin
                        state   <= ST_READ;
                        hi_seen <= 1'b0;
                      end else begin
                        rel_cnt <= rel_cnt + 1'b1;
                      end
          ST_READ: begin
            if (pin_hi)  hi_seen <= 1'b1;
            if (rd_done) state   <= ST_WRITE;
          end
          ST_WRITE: begin
            if (pin_hi) hi_seen <= 1'b1;
            if (wr_done) begin
              remain <= remain - 1'b1;
              if (remain == CNT_W'(1))  state <= ST_FINISH;
              else if (hi_seen || pin_hi) state <= ST_OPEN;
              else                        state <= ST_REARM;
            end
          end
          ST_REARM:   if (pin_hi) state <= ST_OPEN;
          default:    ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dreq_edge_ctrl_chk.sv
module dreq_edge_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic disarm,
  input logic bus_break,
  input logic rd_done,
  input logic wr_done,
  input logic rd_cyc,
  input logic wr_cyc,
  input logic req_held,
  input logic xfer_done
);

  logic quiet;
  assign quiet = !arm && !disarm;

  a_r5_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_cyc, wr_cyc, req_held, xfer_done}));

  a_r3_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    req_held && !bus_break && quiet |=> req_held);

  a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
    req_held && bus_break && quiet |=> !req_held && !rd_cyc);

  a_r4_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_cyc) |-> !$past(req_held, 1) && !$past(req_held, 2));

  a_r5_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc && !rd_done && quiet |=> rd_cyc);

  a_r5_read_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc && rd_done && quiet |=> wr_cyc);

  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc && !wr_done && quiet |=> wr_cyc);

  a_r6_no_hold_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_held) |-> !$past(wr_cyc) && !$past(rd_cyc));

  a_r8_finish_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $past(wr_cyc) || $past(arm));

  a_r9_disarm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !rd_cyc && !wr_cyc && !req_held && !xfer_done);

endmodule

bind dreq_edge_ctrl dreq_edge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
  .bus_break(bus_break), .rd_done(rd_done), .wr_done(wr_done),
  .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .req_held(req_held), .xfer_done(xfer_done)
);

// File: tb/dreq_edge_ctrl_test.sv
`timescale 1ns/1ps
module dreq_edge_ctrl_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, disarm = 1'b0;
  logic [CNT_W-1:0] count_in = '0;
  logic req_n = 1'b1, bus_break = 1'b0, rd_done = 1'b0, wr_done = 1'b0;
  logic rd_cyc, wr_cyc, req_held, xfer_done;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dreq_edge_ctrl #(.CNT_W(CNT_W), .RELEASE_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .count_in(count_in),
    .req_n(req_n), .bus_break(bus_break), .rd_done(rd_done), .wr_done(wr_done),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .req_held(req_held), .xfer_done(xfer_done)
  );

  function automatic logic [3:0] idle_vec();
    return 4'b0000;
  endfunction

  function automatic logic last_of(input int remaining);
    return remaining == 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all_low(input string tag);
    n_cmp++;
    if ({rd_cyc, wr_cyc, req_held, xfer_done} !== idle_vec()) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag,
               {rd_cyc, wr_cyc, req_held, xfer_done}, idle_vec(), $time);
    end
  endtask

  task automatic do_arm(input int cnt);
    count_in = CNT_W'(cnt);
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic do_xfer(input string held_tag, input logic keep_low, input logic last);
    req_n = 1'b0;
    tick(); tick();
    chk("R2 latency", req_held, 1'b0);
    tick();
    chk(held_tag, req_held, 1'b1);
    for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
      tick();
      chk("R3 hold", req_held, 1'b1);
    end
    bus_break = 1'b1;
    tick();
    bus_break = 1'b0;
    chk("R3 clear", req_held, 1'b0);
    chk("R4 gap1", rd_cyc, 1'b0);
    tick();
    chk("R4 gap2", rd_cyc, 1'b0);
    tick();
    chk("R4 read", rd_cyc, 1'b1);
    if (!keep_low) req_n = 1'b1;
    for (int n = 0; n < int'($urandom_range(2, 5)); n++) begin
      tick();
      chk("R5 read hold", rd_cyc, 1'b1);
      chk("R6 no accept rd", req_held, 1'b0);
    end
    rd_done = 1'b1;
    tick();
    rd_done = 1'b0;
    chk("R5 write", wr_cyc, 1'b1);
    chk("R5 read end", rd_cyc, 1'b0);
    for (int m = 0; m < int'($urandom_range(0, 3)); m++) begin
      tick();
      chk("R5 write hold", wr_cyc, 1'b1);
    end
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
    chk("R5 write end", wr_cyc, 1'b0);
    chk("R8 done", xfer_done, last);
    if (!last && keep_low) begin
      for (int k = 0; k < 4; k++) begin
        tick();
        chk("R6 low kept", req_held, 1'b0);
      end
      req_n = 1'b1;
      tick(); tick(); tick();
      chk("R6 rearm", req_held, 1'b0);
    end
  endtask

  task automatic run_session(input int cnt);
    logic prev_low = 1'b1;
    do_arm(cnt);
    for (int i = cnt; i >= 1; i--) begin
      logic kl = 1'($urandom_range(0, 1));
      do_xfer(prev_low ? "R2 held" : "R7 reopen", kl, last_of(i));
      prev_low = kl;
    end
    req_n = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R8 ignore after done", req_held, 1'b0);
    chk("R8 done stays", xfer_done, 1'b1);
    req_n = 1'b1;
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    @(negedge clk);
    tick();
    chk_all_low("R1 reset");
    rst_n = 1'b1;
    req_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R1 no sample before arm", req_held, 1'b0);
    end
    req_n = 1'b1;
    tick(); tick();

    do_arm(1);
    do_xfer("R2 held", 1'b0, 1'b1);
    req_n = 1'b1;
    tick(); tick();

    do_arm(3);
    do_xfer("R2 held", 1'b1, 1'b0);
    do_xfer("R2 held", 1'b0, 1'b0);
    do_xfer("R7 reopen", 1'b0, 1'b1);
    req_n = 1'b1;
    tick(); tick();

    for (int s = 0; s < 8; s++) run_session(int'($urandom_range(1, 5)));

    do_arm(2);
    req_n = 1'b0;
    tick(); tick(); tick();
    chk("R2 held", req_held, 1'b1);
    disarm = 1'b1;
    tick();
    disarm = 1'b0;
    chk_all_low("R9 disarm");
    req_n = 1'b1;
    tick(); tick();
    req_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 closed", req_held, 1'b0);
    end
    req_n = 1'b1;
    tick(); tick();

    count_in = CNT_W'(3);
    arm = 1'b1;
    disarm = 1'b1;
    tick();
    arm = 1'b0;
    disarm = 1'b0;
    req_n = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R9 priority", req_held, 1'b0);
    req_n = 1'b1;
    tick(); tick();

    do_arm(0);
    chk("R8 zero count", xfer_done, 1'b1);
    disarm = 1'b1;
    tick();
    disarm = 1'b0;
    chk_all_low("R9 from done");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule